// File: doc/BRIEF.md
# Fixed-Latency Host Bus Slave

This block is a synchronous slave port for a 16-bit host bus with no acknowledge line. The host reaches it with chip select, output enable and two byte-lane write strobes, and it finds the end of each access only by counting wait states. The block samples every bus pin on the bus clock. It captures a 17-bit address when an access starts. It holds write data in a one-entry buffer and passes it to an internal memory request port. For reads, it presents internal read data on the bus after a fixed number of clocks.

That number of clocks, and the total length of an access, depend on a static 2-bit ratio input. The ratio gives the speed of the internal memory clock relative to the bus clock. The bus data driver is modelled as a data word plus an output-enable signal. The internal side sees single-cycle read and write request pulses.

Top module: `hbus_slave`

## Requirements
- R1: While reset is held and just after it is released, `mem_rd_req`, `mem_wr_req`, `bus_dout_en` and `bus_dout` are all 0.
- R2: An access starts at the first rising edge at which all of the following hold: `bus_cs_n` is 0, at least one of `bus_oe_n`, `bus_we_hi_n` and `bus_we_lo_n` is 0, and `bus_cs_n` has been sampled 1 at some edge since the previous start or since reset. The access is a read if `bus_oe_n` is 0 at that edge, and a write otherwise. `bus_addr` is captured at that edge; later changes of `bus_addr` have no effect on the access.
- R3: A read start raises `mem_rd_req` for exactly one cycle, in the cycle right after the start edge, with `mem_rd_addr` equal to the captured address.
- R4: The read-data edge is N edges after the start edge, where N is 6 for `ratio_sel`=0, 9 for 1, and 12 for 2 or 3. At that edge, if `bus_cs_n` is still 0, `mem_rd_data` is loaded into `bus_dout`. `bus_dout` holds that value until the next read-data edge.
- R5: `bus_dout_en` is 1 only during a read access. It rises after the start edge and falls in the same cycle that `bus_cs_n` goes to 1, with no clock edge in between.
- R6: On a write, `bus_din` and the strobes are latched at the edge 2 after the start edge. At edge 3, if `bus_cs_n` is still 0, `mem_wr_req` pulses for one cycle. The pulse carries the captured address and the latched data, and `mem_wr_be` = {~`bus_we_hi_n`, ~`bus_we_lo_n`}. Bit 1 enables bits 15:8 and bit 0 enables bits 7:0.
- R7: An access ends at the edge T-1 after the start edge, where T is 7, 11 or 13 bus clocks for `ratio_sel` 0, 1 and 2 or 3. Holding `bus_cs_n` at 0 beyond that point starts no further access.
- R8: If `bus_cs_n` is sampled 1 before the access ends, the slave returns to idle at once. A write whose request has not yet been issued is dropped, and no later read-data load occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ratio_sel | input | 2 | Memory-to-bus clock ratio: 0 ÷1, 1 ÷2, 2 or 3 ÷3 |
| bus_cs_n | input | 1 | Chip select, active low |
| bus_oe_n | input | 1 | Read output enable, active low |
| bus_we_hi_n | input | 1 | Upper byte write strobe, active low |
| bus_we_lo_n | input | 1 | Lower byte write strobe, active low |
| bus_addr | input | 17 | Host address |
| bus_din | input | 16 | Write data from the host |
| bus_dout | output | 16 | Read data toward the host |
| bus_dout_en | output | 1 | Drive enable for `bus_dout` |
| mem_rd_req | output | 1 | One-cycle internal read request |
| mem_rd_addr | output | 17 | Internal read address |
| mem_rd_data | input | 16 | Internal read data |
| mem_wr_req | output | 1 | One-cycle internal write request |
| mem_wr_addr | output | 17 | Internal write address |
| mem_wr_data | output | 16 | Internal write data |
| mem_wr_be | output | 2 | Byte enables, bit 1 upper, bit 0 lower |

## Verification
The bench builds the block with its default 17-bit address and 16-bit data widths. It walks `ratio_sel` through all four codes at run time, so the three access lengths, the three read-data edges and the reserved code all run on the same build. The bench changes `mem_rd_data` every clock, so a load one edge early or late shows up as a wrong word. It also changes `bus_addr` right after the start edge, which exposes any address that is not captured. Short chip-select pulses end accesses before the write latch, between the latch and the issue, and before the read-data edge.

// File: rtl/hbs_pkg.sv
package hbs_pkg;
  localparam int AGE_W = 4;
  localparam logic [AGE_W-1:0] WR_LATCH_EDGE = AGE_W'(2);
  localparam logic [AGE_W-1:0] WR_ISSUE_EDGE = AGE_W'(3);

  typedef enum logic [1:0] {
    RATIO_DIV1 = 2'd0,
    RATIO_DIV2 = 2'd1,
    RATIO_DIV3 = 2'd2,
    RATIO_RSVD = 2'd3
  } ratio_e;

  // total bus clocks of an access with chip select low
  function automatic logic [AGE_W-1:0] access_clocks(input logic [1:0] r);
    case (ratio_e'(r))
      RATIO_DIV1: return AGE_W'(7);
      RATIO_DIV2: return AGE_W'(11);
      default:    return AGE_W'(13);
    endcase
  endfunction

  // edge (counted from the start edge) where the access closes
  function automatic logic [AGE_W-1:0] final_edge(input logic [1:0] r);
    return access_clocks(r) - AGE_W'(1);
  endfunction

  // edge (counted from the start edge) where read data is loaded
  function automatic logic [AGE_W-1:0] read_edge(input logic [1:0] r);
    case (ratio_e'(r))
      RATIO_DIV1: return AGE_W'(6);
      RATIO_DIV2: return AGE_W'(9);
      default:    return AGE_W'(12);
    endcase
  endfunction
endpackage

// File: rtl/hbs_seq.sv
module hbs_seq
  import hbs_pkg::*;
#(
  parameter int AW = 17
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    ratio,
  input  logic          cs_n,
  input  logic          oe_n,
  input  logic [1:0]    we_n,
  input  logic [AW-1:0] addr,
  output logic          active,
  output logic          start_ev,
  output logic          abort_ev,
  output logic          end_ev,
  output logic          wlatch_ev,
  output logic          wissue_ev,
  output logic          rcap_ev,
  output logic          drive,
  output logic [AW-1:0] addr_q
);
  logic             armed_q;
  logic             is_rd_q;
  logic             drive_q;
  logic [AGE_W-1:0] age_q;
  logic             hold;
  logic             any_strobe;

  assign any_strobe = !oe_n || (we_n != 2'b11);
  assign start_ev   = !active && armed_q && !cs_n && any_strobe;
  assign hold       = active && !cs_n;
  assign abort_ev   = active && cs_n;
  assign end_ev     = hold && (age_q == final_edge(ratio));
  assign wlatch_ev  = hold && !is_rd_q && (age_q == WR_LATCH_EDGE);
  assign wissue_ev  = hold && !is_rd_q && (age_q == WR_ISSUE_EDGE);
  assign rcap_ev    = hold && is_rd_q && (age_q == read_edge(ratio));
  assign drive      = drive_q && !cs_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active  <= 1'b0;
      armed_q <= 1'b0;
      is_rd_q <= 1'b0;
      drive_q <= 1'b0;
      age_q   <= '0;
      addr_q  <= '0;
    end else begin
      if (cs_n)          armed_q <= 1'b1;
      else if (start_ev) armed_q <= 1'b0;

      if (cs_n)          drive_q <= 1'b0;
      else if (start_ev) drive_q <= !oe_n;

      if (start_ev) begin
        active  <= 1'b1;
        is_rd_q <= !oe_n;
        age_q   <= AGE_W'(1);
        addr_q  <= addr;
      end else if (active) begin
        if (abort_ev || end_ev) active <= 1'b0;
        age_q <= age_q + AGE_W'(1);
      end
    end
  end
endmodule

// File: rtl/hbs_wbuf.sv
module hbs_wbuf #(
  parameter int AW    = 17,
  parameter int DW    = 16,
  parameter int LANES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wlatch_ev,
  input  logic             wissue_ev,
  input  logic             abort_ev,
  input  logic [DW-1:0]    din,
  input  logic [LANES-1:0] we_n,
  input  logic [AW-1:0]    addr_q,
  output logic             wr_req,
  output logic [AW-1:0]    wr_addr,
  output logic [DW-1:0]    wr_data,
  output logic [LANES-1:0] wr_be
);
  localparam int LW = DW / LANES;

  logic [DW-1:0]    buf_data;
  logic [DW-1:0]    data_nxt;
  logic [LANES-1:0] buf_be;
  logic [LANES-1:0] be_nxt;
  logic             buf_vld;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign data_nxt[g*LW +: LW] = wlatch_ev ? din[g*LW +: LW] : buf_data[g*LW +: LW];
    assign be_nxt[g]            = wlatch_ev ? !we_n[g] : buf_be[g];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      buf_data <= '0;
      buf_be   <= '0;
      buf_vld  <= 1'b0;
      wr_req   <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
      wr_be    <= '0;
    end else begin
      buf_data <= data_nxt;
      buf_be   <= be_nxt;
      if (abort_ev)       buf_vld <= 1'b0;
      else if (wlatch_ev) buf_vld <= 1'b1;
      else if (wissue_ev) buf_vld <= 1'b0;

      wr_req <= wissue_ev && buf_vld;
      if (wissue_ev && buf_vld) begin
        wr_addr <= addr_q;
        wr_data <= buf_data;
        wr_be   <= buf_be;
      end
    end
  end
endmodule

// File: rtl/hbs_rdpath.sv
module hbs_rdpath #(
  parameter int AW = 17,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_ev,
  input  logic          oe_n,
  input  logic          rcap_ev,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] rd_data,
  output logic          rd_req,
  output logic [AW-1:0] rd_addr,
  output logic [DW-1:0] dout
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_req  <= 1'b0;
      rd_addr <= '0;
      dout    <= '0;
    end else begin
      rd_req <= start_ev && !oe_n;
      if (start_ev && !oe_n) rd_addr <= addr;
      if (rcap_ev) dout <= rd_data;
    end
  end
endmodule

// File: rtl/hbus_slave.sv
module hbus_slave #(
  parameter int AW = 17,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    ratio_sel,
  input  logic          bus_cs_n,
  input  logic          bus_oe_n,
  input  logic          bus_we_hi_n,
  input  logic          bus_we_lo_n,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_din,
  output logic [DW-1:0] bus_dout,
  output logic          bus_dout_en,
  output logic          mem_rd_req,
  output logic [AW-1:0] mem_rd_addr,
  input  logic [DW-1:0] mem_rd_data,
  output logic          mem_wr_req,
  output logic [AW-1:0] mem_wr_addr,
  output logic [DW-1:0] mem_wr_data,
  output logic [1:0]    mem_wr_be
);
  localparam int LANES = 2;

  logic [LANES-1:0] we_n;
  logic             active;
  logic             start_ev;
  logic             abort_ev;
  logic             end_ev;
  logic             wlatch_ev;
  logic             wissue_ev;
  logic             rcap_ev;
  logic [AW-1:0]    addr_q;

  assign we_n = {bus_we_hi_n, bus_we_lo_n};

  hbs_seq #(.AW(AW)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .ratio     (ratio_sel),
    .cs_n      (bus_cs_n),
    .oe_n      (bus_oe_n),
    .we_n      (we_n),
    .addr      (bus_addr),
    .active    (active),
    .start_ev  (start_ev),
    .abort_ev  (abort_ev),
    .end_ev    (end_ev),
    .wlatch_ev (wlatch_ev),
    .wissue_ev (wissue_ev),
    .rcap_ev   (rcap_ev),
    .drive     (bus_dout_en),
    .addr_q    (addr_q)
  );

  hbs_wbuf #(.AW(AW), .DW(DW), .LANES(LANES)) u_wbuf (
    .clk       (clk),
    .rst_n     (rst_n),
    .wlatch_ev (wlatch_ev),
    .wissue_ev (wissue_ev),
    .abort_ev  (abort_ev),
    .din       (bus_din),
    .we_n      (we_n),
    .addr_q    (addr_q),
    .wr_req    (mem_wr_req),
    .wr_addr   (mem_wr_addr),
    .wr_data   (mem_wr_data),
    .wr_be     (mem_wr_be)
  );

  hbs_rdpath #(.AW(AW), .DW(DW)) u_rd (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_ev (start_ev),
    .oe_n     (bus_oe_n),
    .rcap_ev  (rcap_ev),
    .addr     (bus_addr),
    .rd_data  (mem_rd_data),
    .rd_req   (mem_rd_req),
    .rd_addr  (mem_rd_addr),
    .dout     (bus_dout)
  );
endmodule

// File: rtl/hbs_chk.sv
module hbs_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_cs_n,
  input logic          bus_oe_n,
  input logic          bus_dout_en,
  input logic          mem_rd_req,
  input logic          mem_wr_req,
  input logic [DW-1:0] bus_dout,
  input logic [DW-1:0] mem_rd_data,
  input logic          active,
  input logic          abort_ev,
  input logic          end_ev,
  input logic          rcap_ev
);
  // R3
  rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_req |=> !mem_rd_req);
  // R3
  rd_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_req |-> $past(!bus_oe_n && !bus_cs_n));
  // R6
  wr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_req |=> !mem_wr_req);
  // R5
  oe_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_dout_en |-> !bus_cs_n);
  // R5
  oe_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_req |-> !bus_dout_en);
  // R4
  dout_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rcap_ev |=> (bus_dout == $past(mem_rd_data)));
  // R7
  end_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    end_ev |=> !active);
  // R8
  abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort_ev |=> !active);
endmodule

bind hbus_slave hbs_chk #(.DW(DW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_cs_n    (bus_cs_n),
  .bus_oe_n    (bus_oe_n),
  .bus_dout_en (bus_dout_en),
  .mem_rd_req  (mem_rd_req),
  .mem_wr_req  (mem_wr_req),
  .bus_dout    (bus_dout),
  .mem_rd_data (mem_rd_data),
  .active      (active),
  .abort_ev    (abort_ev),
  .end_ev      (end_ev),
  .rcap_ev     (rcap_ev)
);

// File: tb/tb_hbus_slave.sv
`timescale 1ns/1ps
module tb_hbus_slave;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  ratio_sel = 2'd0;
  logic        bus_cs_n = 1'b1, bus_oe_n = 1'b1, bus_we_hi_n = 1'b1, bus_we_lo_n = 1'b1;
  logic [16:0] bus_addr = '0;
  logic [15:0] bus_din = '0;
  logic [15:0] bus_dout;
  logic        bus_dout_en;
  logic        mem_rd_req;
  logic [16:0] mem_rd_addr;
  logic [15:0] mem_rd_data = '0;
  logic        mem_wr_req;
  logic [16:0] mem_wr_addr;
  logic [15:0] mem_wr_data;
  logic [1:0]  mem_wr_be;

  int checks = 0, fails = 0, n_rd = 0, n_wr = 0, cyc = 0;

  always #2.5 clk = ~clk;

  hbus_slave dut (.*);

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int t_len(input logic [1:0] r);
    return (r == 2'd0) ? 7 : ((r == 2'd1) ? 11 : 13);
  endfunction
  function automatic int t_rd(input logic [1:0] r);
    return (r >= 2'd2) ? 12 : 6 + 3 * int'(r);
  endfunction

  // changing internal read data every clock
  always @(negedge clk) begin
    cyc++;
    mem_rd_data <= 16'h5A00 ^ cyc[15:0];
  end

  // behavioural reference, compared each clock
  int m_age = 0;
  bit m_on = 0, m_rd = 0, m_arm = 0, m_wq = 0, m_drv = 0;
  bit e_rd = 0, e_wr = 0;
  logic [16:0] m_addr = '0, e_raddr = '0, e_waddr = '0;
  logic [15:0] m_wdat = '0, e_wdat = '0, e_dout = '0;
  logic [1:0]  m_wbe = '0, e_wbe = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_on = 0; m_arm = 0; m_wq = 0; m_drv = 0; e_rd = 0; e_wr = 0; e_dout = '0;
    end else begin
      e_rd = 0; e_wr = 0;
      if (m_on) begin
        m_age++;
        if (bus_cs_n) begin m_on = 0; m_wq = 0; end
        else begin
          if (!m_rd && m_age == 2) begin
            m_wdat = bus_din; m_wbe = {~bus_we_hi_n, ~bus_we_lo_n}; m_wq = 1;
          end
          if (!m_rd && m_age == 3 && m_wq) begin
            e_wr = 1; e_waddr = m_addr; e_wdat = m_wdat; e_wbe = m_wbe; m_wq = 0;
          end
          if (m_rd && m_age == t_rd(ratio_sel)) e_dout = mem_rd_data;
          if (m_age == t_len(ratio_sel) - 1) m_on = 0;
        end
      end else if (m_arm && !bus_cs_n && (!bus_oe_n || !bus_we_hi_n || !bus_we_lo_n)) begin
        m_on = 1; m_age = 0; m_rd = !bus_oe_n; m_addr = bus_addr; m_arm = 0; m_wq = 0;
        m_drv = m_rd;
        if (m_rd) begin e_rd = 1; e_raddr = bus_addr; end
      end
      if (bus_cs_n) begin m_arm = 1; m_drv = 0; end
    end
    #1;
    if (rst_n) begin
      if (mem_rd_req) n_rd++;
      if (mem_wr_req) n_wr++;
      chk(mem_rd_req === e_rd, "R3 rd_req", 32'(mem_rd_req), 32'(e_rd));
      if (e_rd) chk(mem_rd_addr === e_raddr, "R2/R3 rd_addr", 32'(mem_rd_addr), 32'(e_raddr));
      chk(mem_wr_req === e_wr, "R6/R8 wr_req", 32'(mem_wr_req), 32'(e_wr));
      if (e_wr) begin
        chk(mem_wr_addr === e_waddr, "R2/R6 wr_addr", 32'(mem_wr_addr), 32'(e_waddr));
        chk(mem_wr_data === e_wdat, "R6 wr_data", 32'(mem_wr_data), 32'(e_wdat));
        chk(mem_wr_be === e_wbe, "R6 wr_be", 32'(mem_wr_be), 32'(e_wbe));
      end
      chk(bus_dout === e_dout, "R4 dout", 32'(bus_dout), 32'(e_dout));
      chk(bus_dout_en === (m_drv && !bus_cs_n), "R5 dout_en", 32'(bus_dout_en), 32'(m_drv && !bus_cs_n));
    end
  end

  // lead: clocks with cs low before strobes; hold: edges with cs and strobe low
  task automatic xfer(input bit rd, input logic [16:0] a, input logic [15:0] d,
                      input bit hi, input bit lo, input int hold, input int lead);
    @(negedge clk);
    bus_cs_n = 1'b0; bus_addr = a;
    repeat (lead) @(negedge clk);
    bus_oe_n = !rd; bus_we_hi_n = !(!rd && hi); bus_we_lo_n = !(!rd && lo); bus_din = d;
    @(negedge clk);
    bus_addr = ~a;
    repeat (hold - 1) @(negedge clk);
    bus_cs_n = 1'b1; bus_oe_n = 1'b1; bus_we_hi_n = 1'b1; bus_we_lo_n = 1'b1;
    #0.5;
    chk(bus_dout_en === 1'b0, "R5 en drops with cs", 32'(bus_dout_en), 32'd0);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(mem_rd_req === 1'b0 && mem_wr_req === 1'b0, "R1 reqs in reset", 32'({mem_rd_req, mem_wr_req}), 32'd0);
    chk(bus_dout_en === 1'b0 && bus_dout === '0, "R1 dout in reset", 32'(bus_dout), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(mem_rd_req === 1'b0 && bus_dout_en === 1'b0, "R1 after release", 32'({mem_rd_req, bus_dout_en}), 32'd0);

    for (int r = 0; r < 4; r++) begin
      int b_rd, b_wr;
      ratio_sel = 2'(r);
      b_rd = n_rd; b_wr = n_wr;
      xfer(1, 17'h1_0A00 + 17'(r), 16'h0, 0, 0, t_len(2'(r)), 0);
      xfer(0, 17'h0_0B10 + 17'(r), 16'hC3A5 ^ 16'(r), 1, 1, t_len(2'(r)), 0);
      xfer(0, 17'h1_FFFF, 16'h1234, 1, 0, t_len(2'(r)), 0);
      xfer(0, 17'h0_0000, 16'hABCD, 0, 1, t_len(2'(r)), 0);
      chk(n_rd - b_rd == 1, "R3 one read per access", 32'(n_rd - b_rd), 32'd1);
      chk(n_wr - b_wr == 3, "R6 one write per access", 32'(n_wr - b_wr), 32'd3);
      // R4 read-data edge per ratio, loaded before cs rises
      xfer(1, 17'h0_4444, 16'h0, 0, 0, t_rd(2'(r)) + 1, 0);
    end

    ratio_sel = 2'd0;
    begin
      int b;
      // R2 cs low first, strobe later: starts when strobe arrives
      b = n_rd;
      xfer(1, 17'h0_0777, 16'h0, 0, 0, 7, 3);
      chk(n_rd - b == 1, "R2 late strobe starts access", 32'(n_rd - b), 32'd1);
      // R7 cs held far beyond the access: no second start
      b = n_rd;
      xfer(1, 17'h0_0888, 16'h0, 0, 0, 30, 0);
      chk(n_rd - b == 1, "R7 no restart while cs low", 32'(n_rd - b), 32'd1);
      // R8 aborts before latch, between latch and issue, and during a read
      b = n_wr;
      xfer(0, 17'h0_0999, 16'hFFFF, 1, 1, 2, 0);
      xfer(0, 17'h0_0AAA, 16'hEEEE, 1, 1, 3, 0);
      chk(n_wr - b == 0, "R8 aborted writes dropped", 32'(n_wr - b), 32'd0);
      ratio_sel = 2'd2;
      xfer(1, 17'h0_0BBB, 16'h0, 0, 0, 4, 0);
      b = n_wr;
      xfer(0, 17'h0_0CCC, 16'h5555, 1, 1, 4, 0);
      chk(n_wr - b == 1, "R8 write issued before cs rise kept", 32'(n_wr - b), 32'd1);
    end

    repeat (4) @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule